// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early Warning

The block is a watchdog built around an 8-bit down-counter. The counter steps down once per slow tick, and a prescaler in front of it makes that tick from the system clock. Software controls the block with single-cycle control writes. Each write carries a count value, a one-bit command (start or stop) and a 7-bit key. A command takes effect only when its key is the bitwise complement of the key from the last command that was accepted. Each new command must therefore flip every key bit. A stray or repeated write cannot restart or stop the timer.

Once started, the counter counts toward zero. When it reaches one, an interrupt request for the non-maskable input goes high. This gives software one last tick in which to react. At zero, a chip-reset request goes high as well. A start command reloads the counter and clears both requests. A start sent while the timer is already running is the normal way to service it. A stop command freezes the counter and drops both requests.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is stopped, `wd_count` is 0, and `nmi_req` and `chip_rst` are low.
- R2: Before any command has been accepted, a start command (`ctl_cmd`=1) is accepted whatever its key, and that key becomes the stored key. A stop command (`ctl_cmd`=0) sent in this state is ignored.
- R3: Once a key is stored, a write is accepted only when `ctl_key` equals the stored key XOR 7'h7F. An accepted write replaces the stored key with its own key.
- R4: A write with any other key is ignored entirely. The count, the running state and the stored key all stay unchanged.
- R5: An accepted start loads `ctl_cnt` into the counter on the next clock edge and restarts the prescaler. It does this in the same way whether the timer was stopped or running.
- R6: While the timer runs, the counter decrements exactly once every PRESCALE clocks, counted from the start. It stays at 0 once it gets there.
- R7: `nmi_req` is high exactly while the timer runs with a count of 1 or 0. It therefore stays high until a reload or a stop.
- R8: `chip_rst` is high exactly while the timer runs with a count of 0.
- R9: An accepted stop halts the counter at its present value and drops `nmi_req` and `chip_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe, one cycle per write |
| ctl_cmd | input | 1 | Command: 1 = start/reload, 0 = stop |
| ctl_key | input | 7 | Key presented with the command |
| ctl_cnt | input | 8 | Start value loaded by a start command |
| wd_count | output | 8 | Present counter value |
| nmi_req | output | 1 | Early warning request (count at 1 or 0) |
| chip_rst | output | 1 | Chip reset request (count at 0) |

## Verification
The bench targets the key sequence. It sends wrong keys right after a good one, repeats the same key twice, and sends a stop before any start. A design that stored a rejected key, or that did not demand inversion, would accept a later write that should fail, or reject one that should pass, and the count would then diverge. Reloads are placed mid-period so that a prescaler left running across a restart shows up as an early decrement. Loads of 1 and 0 check that the early warning and the reset appear in the cycle after the load. Expiry and a stop after expiry check that both requests hold, and then clear, when they should.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int PRESCALE = 131072,
  parameter int CNT_W    = 8,
  parameter int KEY_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_cmd,
  input  logic [KEY_W-1:0] ctl_key,
  input  logic [CNT_W-1:0] ctl_cnt,
  output logic [CNT_W-1:0] wd_count,
  output logic             nmi_req,
  output logic             chip_rst
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [KEY_W-1:0] FLIP = '1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0]    pre;
  logic [CNT_W-1:0] cnt;
  logic [KEY_W-1:0] key_q;
  logic             run, key_vld;

  wire key_ok = key_vld ? (ctl_key == (key_q ^ FLIP)) : ctl_cmd;
  wire accept = ctl_we && key_ok;
  wire tick   = run && (pre == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      cnt     <= '0;
      key_q   <= '0;
      run     <= 1'b0;
      key_vld <= 1'b0;
    end else if (accept) begin
      key_q   <= ctl_key;
      key_vld <= 1'b1;
      pre     <= '0;
      run     <= ctl_cmd;
      if (ctl_cmd) cnt <= ctl_cnt;
    end else if (run) begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign wd_count = cnt;
  assign nmi_req  = run && (cnt <= CNT_W'(1));
  assign chip_rst = run && (cnt == '0);

  // R6
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> cnt <= $past(cnt));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && cnt != '0) |=> cnt >= $past(cnt) - 1'b1);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !accept) |=> $stable(cnt));

  // R8
  rst_implies_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> nmi_req);

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ctl_cmd) |=> (cnt == $past(ctl_cnt)) && !$past(chip_rst && 1'b0));

  // R4
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !key_ok) |=> $stable(key_q) && $stable(run));
endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
  localparam int P = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, cmd = 1'b0;
  logic [6:0] key = '0;
  logic [7:0] ld = '0;
  logic [7:0] wd_count;
  logic nmi_req, chip_rst;
  int checks = 0, fails = 0;
  bit done = 0;

  int m_pre = 0, m_cnt = 0;
  bit m_run = 0, m_kv = 0;
  logic [6:0] m_key = '0;

  always #4 clk = ~clk;

  keyed_watchdog #(.PRESCALE(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(we), .ctl_cmd(cmd), .ctl_key(key),
    .ctl_cnt(ld), .wd_count(wd_count), .nmi_req(nmi_req), .chip_rst(chip_rst));

  function automatic bit acc_ok(bit c, logic [6:0] k);
    return m_kv ? (k == (m_key ^ 7'h7F)) : c;
  endfunction

  task automatic model_step();
    if (we && acc_ok(cmd, key)) begin
      m_key = key; m_kv = 1; m_pre = 0; m_run = cmd;
      if (cmd) m_cnt = ld;
    end else if (m_run) begin
      if (m_pre == P-1) begin
        m_pre = 0;
        if (m_cnt != 0) m_cnt--;
      end else m_pre++;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " R6 count"}, wd_count, m_cnt);
    chk({tag, " R7 nmi"}, nmi_req, (m_run && m_cnt <= 1));
    chk({tag, " R8 rst"}, chip_rst, (m_run && m_cnt == 0));
  endtask

  task automatic cyc(string tag, bit w, bit c, logic [6:0] k, logic [7:0] v);
    we = w; cmd = c; key = k; ld = v;
    @(posedge clk);
    model_step();
    @(negedge clk);
    we = 0;
    compare(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 7'h0, 8'h0);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout");
      report();
    end
  end

  initial begin
    logic [6:0] gk;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", wd_count, 0);
    chk("R1 nmi", nmi_req, 0);
    chk("R1 rst", chip_rst, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 stop before any start ignored
    cyc("R2 early stop", 1, 0, 7'h15, 8'h33);
    idle("R2", 3);
    // R2 first start with arbitrary key
    cyc("R2 first start", 1, 1, 7'h2A, 8'd5);
    chk("R5 load", wd_count, 5);
    idle("R6 run", 6);
    // R4 same key repeated ignored
    cyc("R4 repeat key", 1, 1, 7'h2A, 8'd40);
    chk("R4 not loaded", wd_count, m_cnt);
    // R4 random wrong key, then R3 inverted old key still accepted
    cyc("R4 wrong key", 1, 0, 7'h11, 8'd0);
    cyc("R3 good key", 1, 1, 7'h55, 8'd9);
    chk("R3 accepted", wd_count, 9);
    // R5 restart mid-period restarts prescaler
    idle("R5", 2);
    cyc("R5 restart", 1, 1, 7'h2A, 8'd9);
    idle("R5 prescale", P);
    chk("R5 one step", wd_count, 8);
    // R7 load 1
    cyc("R7 load1", 1, 1, 7'h55, 8'd1);
    chk("R7 nmi now", nmi_req, 1);
    idle("R8 expire", 2*P);
    chk("R8 rst held", chip_rst, 1);
    chk("R7 nmi held", nmi_req, 1);
    // R9 stop clears requests
    cyc("R9 stop", 1, 0, 7'h2A, 8'd0);
    chk("R9 nmi off", nmi_req, 0);
    idle("R9 frozen", 2*P);
    // R8 load 0
    cyc("R8 load0", 1, 1, 7'h55, 8'd0);
    chk("R8 rst now", chip_rst, 1);
    cyc("R9 stop2", 1, 0, 7'h2A, 8'd0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 8) begin
        gk = ($urandom_range(0, 1) == 0) ? (m_key ^ 7'h7F) : 7'($urandom);
        cyc("R3 rand", 1, ($urandom_range(0, 3) != 0),
            gk, 8'($urandom_range(0, 12)));
      end else cyc("R6 rand", 0, 0, 7'h0, 8'h0);
    end
    done = 1;
    report();
  end
endmodule